// File: doc/BRIEF.md
# Multi-Mode Sensor Sample Buffer

This block stores sample sets from a sensor sampling engine until a host takes them through a register read port. The sampling engine presents a write strobe with a sample word once per output-data-rate tick. The host pops the oldest unread word with a read strobe. The read port always shows the oldest unread word, so the host reads it and pops it in the same cycle.

A 2-bit mode input selects one of four fill policies at run time:
- **Bypass:** nothing is stored and the port shows the latest sample.
- **Hold:** the buffer fills, then refuses new samples when full.
- **Stream:** when full, the newest sample replaces the oldest one.
- **Trigger-switched:** the buffer streams until an external trigger asserts, then holds.

A packed status byte reports:
- a watermark flag,
- an overrun flag, which clears on the first read after overflow,
- an empty flag,
- a saturating 5-bit unread count.

Top module: `sensor_sample_fifo`

## Requirements
- R1: With mode 2'b00 (bypass), nothing is stored. From the cycle after bypass is selected, the count field is 0, EMPTY is 1 and OVRN is 0. While bypass is selected, the read port shows the most recent written sample.
- R2: With mode 2'b01 (hold), up to 32 samples are kept. A write that arrives while 32 are held, without a read in the same cycle, is discarded.
- R3: With mode 2'b10 (stream), a write that arrives while 32 are held, without a read, replaces the oldest stored sample. The next-oldest sample becomes the head.
- R4: With mode 2'b11 (trigger), the buffer behaves as stream while the trigger input is low and as hold while it is high.
- R5: Outside bypass, the read port shows the oldest unread sample whenever the buffer is not empty. A read strobe removes that sample. A read strobe while the buffer is empty has no effect.
- R6: The unread count rises by one on each stored write and falls by one on each read. A read and a write in the same cycle leave it unchanged. The count field saturates at 31.
- R7: OVRN goes high when a write brings the buffer to 32 unread samples. It clears on the next read.
- R8: EMPTY is 1 exactly when no unread samples are held.
- R9: WTM is 1 exactly when the number of unread samples is greater than the watermark level input.
- R10: The status byte carries WTM in bit 7, OVRN in bit 6, EMPTY in bit 5 and the count field in bits 4:0.
- R11: After reset, the status byte is 8'h20 and the read port shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Fill policy: 00 bypass, 01 hold, 10 stream, 11 trigger |
| trig_i | input | 1 | Switches trigger mode from stream to hold |
| wtm_lvl_i | input | PTR_W (5) | Watermark level |
| wr_en_i | input | 1 | Sample write strobe, one per data-rate tick |
| wr_data_i | input | DATA_W (16) | Sample word |
| rd_en_i | input | 1 | Host pop strobe |
| rd_data_o | output | DATA_W (16) | Oldest unread sample, or the live sample in bypass |
| status_o | output | PTR_W+3 (8) | {WTM, OVRN, EMPTY, count} |

## Verification
The watermark comparison is swept over every level against every occupancy from 0 to 32. A design that used greater-or-equal, or dropped the top bit of the occupancy, raises WTM one step early or at the wrong point.

Full-buffer writes are driven in each mode, with and without a read in the same cycle:
- A design that mixes up drop and overwrite returns the wrong head word.
- A design that lets the count wrap shows 0 instead of 31.
- A design that keeps OVRN set after a pop leaves the flag high.

Trigger toggling in the middle of a run, and returns to bypass with data held, check that the policy follows the inputs and that bypass empties the buffer.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'b00,
        MODE_HOLD   = 2'b01,
        MODE_STREAM = 2'b10,
        MODE_TRIG   = 2'b11
    } fill_mode_e;

    // number of flag bits packed above the count field
    localparam int unsigned FLAG_BITS = 3;

endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             trig_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    output logic             push_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [OCC_W-1:0] occ_o,
    output logic             ovr_o,
    output logic             bypass_o
);

    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [OCC_W-1:0] occ;
        logic             ovr;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic is_byp, hold_eff, full, pop, push, drop_old;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        is_byp   = (mode_i == MODE_BYPASS);
        hold_eff = (mode_i == MODE_HOLD) || ((mode_i == MODE_TRIG) && trig_i);
        full     = (st_q.occ == OCC_FULL);
        pop      = rd_en_i && (st_q.occ != '0) && !is_byp;
        push     = wr_en_i && !is_byp && (!full || pop || !hold_eff);
        drop_old = push && full && !pop;

        st_d = st_q;
        if (is_byp) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.occ  = '0;
            st_d.ovr  = 1'b0;
        end else begin
            if (push)            st_d.wptr = nxt(st_q.wptr);
            if (pop || drop_old) st_d.rptr = nxt(st_q.rptr);
            st_d.occ = st_q.occ + OCC_W'(push) - OCC_W'(pop) - OCC_W'(drop_old);
            if (pop)
                st_d.ovr = 1'b0;
            else if (push && (st_d.occ == OCC_FULL))
                st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push_o   = push;
    assign wr_ptr_o = st_q.wptr;
    assign rd_ptr_o = st_q.rptr;
    assign occ_o    = st_q.occ;
    assign ovr_o    = st_q.ovr;
    assign bypass_o = is_byp;

    // R1
    bypass_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_BYPASS) |=> (st_q.occ == '0 && !st_q.ovr));

    // R2
    hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_eff && full && wr_en_i && !rd_en_i)
        |=> (st_q.occ == OCC_FULL && st_q.rptr == $past(st_q.rptr)));

    // R3
    stream_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_eff && !is_byp && full && wr_en_i && !rd_en_i)
        |=> (st_q.occ == OCC_FULL && st_q.rptr == nxt($past(st_q.rptr))));

    // R6
    pop_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (st_q.occ == $past(st_q.occ) - OCC_W'(1)));

    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !st_q.ovr);

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              push_i,
    input  logic [PTR_W-1:0]  wr_ptr_i,
    input  logic [PTR_W-1:0]  rd_ptr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              bypass_i,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct {
        logic [DATA_W-1:0] mem [DEPTH];
        logic [DATA_W-1:0] live;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.live = wr_data_i;
        if (push_i)  st_d.mem[wr_ptr_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) st_q.mem[i] <= '0;
            st_q.live <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = bypass_i ? st_q.live : st_q.mem[rd_ptr_i];

    // R1
    live_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (st_q.live == $past(wr_data_i)));

endmodule

// File: rtl/sfifo_status.sv
module sfifo_status
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned OCC_W = PTR_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [OCC_W-1:0]           occ_i,
    input  logic                       ovr_i,
    input  logic [PTR_W-1:0]           wtm_lvl_i,
    output logic [PTR_W+FLAG_BITS-1:0] status_o
);

    localparam logic [PTR_W-1:0] CNT_MAX = PTR_W'(DEPTH - 1);

    logic             wtm, empty;
    logic [PTR_W-1:0] cnt;

    always_comb begin
        wtm   = occ_i > {1'b0, wtm_lvl_i};
        empty = (occ_i == '0);
        cnt   = (occ_i > OCC_W'(CNT_MAX)) ? CNT_MAX : occ_i[PTR_W-1:0];
        status_o = {wtm, ovr_i, empty, cnt};
    end

    // R8
    empty_zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[PTR_W] |-> (status_o[PTR_W-1:0] == '0 && !status_o[PTR_W+2]));

endmodule

// File: rtl/sensor_sample_fifo.sv
module sensor_sample_fifo
    import sfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned OCC_W = PTR_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 mode_i,
    input  logic                       trig_i,
    input  logic [PTR_W-1:0]           wtm_lvl_i,
    input  logic                       wr_en_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic                       rd_en_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [PTR_W+FLAG_BITS-1:0] status_o
);

    logic             push, ovr, bypass;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;

    sfifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OCC_W(OCC_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_i),
        .trig_i   (trig_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .push_o   (push),
        .wr_ptr_o (wr_ptr),
        .rd_ptr_o (rd_ptr),
        .occ_o    (occ),
        .ovr_o    (ovr),
        .bypass_o (bypass)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .push_i    (push),
        .wr_ptr_i  (wr_ptr),
        .rd_ptr_i  (rd_ptr),
        .wr_data_i (wr_data_i),
        .bypass_i  (bypass),
        .rd_data_o (rd_data_o)
    );

    sfifo_status #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OCC_W(OCC_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .occ_i     (occ),
        .ovr_i     (ovr),
        .wtm_lvl_i (wtm_lvl_i),
        .status_o  (status_o)
    );

endmodule

// File: tb/sensor_sample_fifo_bench.sv
`timescale 1ns/1ps
module sensor_sample_fifo_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        trig_i = 1'b0;
    logic [4:0]  wtm_lvl_i = 5'd0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = 16'h0;
    logic        rd_en_i = 1'b0;
    logic [15:0] rd_data_o;
    logic [7:0]  status_o;

    always #2 clk = ~clk;

    sensor_sample_fifo u_sensor_sample_fifo (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .trig_i(trig_i),
        .wtm_lvl_i(wtm_lvl_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .status_o(status_o)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string phase = "R11";

    // reference model
    int unsigned q[$];
    int unsigned live = 0;
    bit          ovr = 0;
    // staged controls, applied at the next tick
    logic [1:0]  nx_mode = 2'b00;
    logic        nx_trig = 1'b0;
    logic [4:0]  nx_lvl = 5'd0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h (t=%0t)", phase, req, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        int unsigned n = q.size();
        bit e_wtm   = n > wtm_lvl_i;
        bit e_empty = (n == 0);
        int unsigned e_cnt = (n > 31) ? 31 : n;
        logic [7:0] e_byte = {e_wtm, ovr, e_empty, 5'(e_cnt)};
        chk(status_o == e_byte, "R10 status byte", status_o, e_byte);
        chk(status_o[4:0] == 5'(e_cnt), "R6 count", status_o[4:0], e_cnt);
        chk(status_o[6] == ovr, "R7 ovrn", status_o[6], ovr);
        chk(status_o[5] == e_empty, "R8 empty", status_o[5], e_empty);
        chk(status_o[7] == e_wtm, "R9 wtm", status_o[7], e_wtm);
        if (mode_i == 2'b00)
            chk(rd_data_o == 16'(live), "R1 live data", rd_data_o, live);
        else if (n > 0)
            chk(rd_data_o == 16'(q[0]), "R5 head data", rd_data_o, q[0]);
    endtask

    task automatic model_step(input bit wr, input bit rd, input logic [15:0] d);
        bit hold = (mode_i == 2'b01) || (mode_i == 2'b11 && trig_i);
        bit popped = 0;
        if (wr) live = d;
        if (mode_i == 2'b00) begin
            q.delete();
            ovr = 0;
            return;
        end
        if (rd && q.size() > 0) begin
            void'(q.pop_front());
            popped = 1;
        end
        if (wr) begin
            if (q.size() < 32) begin
                q.push_back(d);
                if (q.size() == 32 && !popped) ovr = 1;
            end else if (!hold) begin
                void'(q.pop_front());
                q.push_back(d);
                if (!popped) ovr = 1;
            end
        end
        if (popped) ovr = 0;
    endtask

    task automatic tick(input bit wr, input bit rd, input logic [15:0] d);
        @(negedge clk);
        check_outputs();
        mode_i = nx_mode; trig_i = nx_trig; wtm_lvl_i = nx_lvl;
        wr_en_i = wr; rd_en_i = rd; wr_data_i = d;
        model_step(wr, rd, d);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(status_o == 8'h20, "R11 reset status", status_o, 8'h20);
        chk(rd_data_o == 16'h0, "R11 reset data", rd_data_o, 0);
        rst_n = 1'b1;

        // R1: bypass stores nothing, shows live sample
        phase = "R1";
        for (int i = 0; i < 12; i++) tick(1, i[0], 16'(16'h1000 + i));
        for (int i = 0; i < 3; i++) tick(0, 1, 16'h0);

        // R2: hold mode, fill past full, writes dropped
        phase = "R2"; nx_mode = 2'b01; nx_lvl = 5'd20;
        for (int i = 0; i < 40; i++) tick(1, 0, 16'(16'h2000 + i));
        tick(1, 1, 16'h2FFF);            // read+write at full
        for (int i = 0; i < 36; i++) tick(0, 1, 16'h0);   // includes reads on empty (R5)

        // R3: stream mode overwrites oldest
        phase = "R3"; nx_mode = 2'b10;
        for (int i = 0; i < 45; i++) tick(1, 0, 16'(16'h3000 + i));
        for (int i = 0; i < 10; i++) tick(1, 1, 16'(16'h3100 + i));
        for (int i = 0; i < 34; i++) tick(0, 1, 16'h0);

        // R4: trigger mode, stream then hold
        phase = "R4"; nx_mode = 2'b11; nx_trig = 1'b0;
        for (int i = 0; i < 40; i++) tick(1, 0, 16'(16'h4000 + i));
        nx_trig = 1'b1;
        for (int i = 0; i < 6; i++) tick(1, 0, 16'(16'h4100 + i));
        for (int i = 0; i < 5; i++) tick(1, 1, 16'(16'h4200 + i));
        nx_trig = 1'b0;
        for (int i = 0; i < 3; i++) tick(1, 0, 16'(16'h4300 + i));
        // back to bypass with data held: must empty
        nx_mode = 2'b00;
        tick(0, 0, 16'h0);
        tick(0, 0, 16'h0);

        // R9: watermark sweep, every level against every occupancy
        phase = "R9"; nx_mode = 2'b01;
        for (int lvl = 0; lvl < 32; lvl++) begin
            nx_lvl = 5'(lvl);
            for (int i = 0; i < 33; i++) tick(1, 0, 16'(lvl * 64 + i));
            for (int i = 0; i < 33; i++) tick(0, 1, 16'h0);
        end

        // R6: mixed traffic across all modes
        phase = "R6";
        for (int i = 0; i < 2400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 300 == 0) nx_mode = 2'((i / 300) % 4);
            if (i % 37 == 0) nx_trig = ~nx_trig;
            if (i % 101 == 0) nx_lvl = lfsr[4:0];
            tick(lfsr[0] | lfsr[3], lfsr[1] & lfsr[5], lfsr);
        end
        tick(0, 0, 16'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule